// File: doc/BRIEF.md
# Bridge Configuration Header Register File

This block holds the configuration header that a PCI-to-PCI bridge presents at a root port. A build parameter can add a PCI Express capability structure after the header. A requester issues one access per cycle: a dword-aligned read or write of 1, 2 or 4 bytes. The response comes back on the next cycle.

Each bit has one fixed access class, taken from a constant table indexed by dword number. The classes are writable, read-only, write-one-to-clear and reserved (always zero). Platform logic can supply a live value for the dword being accessed through an override input. Every committed write is reported on a notification output, so that the same logic can react to it. That output carries the dword index, the value before the write, the value after it and the active byte lanes.

Top module: `cfg_bridge_regfile`

## Requirements
- R1: After reset, the header holds these values:
  - 0x00 reads `ID_WORD`.
  - 0x04 reads 0x00100000 (capability-list status bit 20 set).
  - 0x08 reads 0x0604 in bits 31:16 and `REV_ID` in bits 7:0.
  - 0x0C reads 0x00010010.
  - 0x34 reads 0x40 with the capability and 0 without it.
  - With the capability, 0x40 reads 0x01420010 (ID 0x10; flags version 2, root port, slot).
  - Every other dword reads 0.
- R2: The dword index is `addr[ADDR_W-1:2]`. A 1-byte read returns `(dword >> 8*addr[1:0]) & 0xFF`. A 2-byte read returns the same shift masked to 0xFFFF. A 4-byte read returns the full dword, shifted by the same amount.
- R3: A size code other than 1, 2 or 4 sets `rsp_err` for an in-range address. Such a request returns zero, changes no register and raises no notification.
- R4: The implemented region ends at 0x7C with the capability and at 0x40 without it. A read at or above this limit returns 0 with no error, and a write there is dropped with no notification.
- R5: Reserved bits read as zero, even when the override supplies ones. Reserved masks by dword offset:
  - 0x04 0x004FFC00
  - 0x1C 0x005F0000
  - 0x34 0xFFFFFF00
  - 0x38 0x000007FE
  - 0x3C 0xF0100000
  - 0x48 0xFFE00000
  - 0x4C 0x00800000
  - 0x50 0x0000F004
  - 0x58 0xFE00E000
  - 0x5C 0xFFFEFFE0
  - 0x60 0xFFFC0000
- R6: The write lane mask is 0xFFFFFFFF, 0xFFFF<<8*addr[1:0] or 0xFF<<8*addr[1:0] for size 4, 2 or 1. The write data is shifted left by 8*addr[1:0]. Writable bits inside the lane mask take the data. Writable masks by dword offset:
  - 0x04 0x00000147
  - 0x18 0x00FFFFFF
  - 0x1C 0x0000F0F0
  - 0x20 and 0x24 0xFFF0FFF0
  - 0x28, 0x2C and 0x30 all ones
  - 0x38 0xFFFFF801
  - 0x3C 0x0B6F00FF
  - 0x48 0x0000FFFF
  - 0x50 0x00000FFB
  - 0x58 0x00001FFF
  - 0x5C 0x0000001F
- R7: A write-one-to-clear bit inside the lane mask clears when written with 1. Masks by dword offset:
  - 0x04 and 0x1C 0xF9000000
  - 0x3C 0x04000000
  - 0x48 0x000F0000
  - 0x50 0xC0000000
  - 0x58 0x011F0000
  - 0x60 0x00010000
- R8: Every bit not writable in R6 keeps its value across any write.
- R9: `ovr_idx` shows the dword index of the current request combinationally. While `ovr_valid` is high, `ovr_data` replaces the stored dword as the read source. It is also the old value used by the write merge.
- R10: One cycle after a committed write, `wn_valid` pulses with:
  - the dword index;
  - the old value (override applied, reserved cleared);
  - the merged new value;
  - the lane mask.

  The new value is what later reads return.
- R11: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset in configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| ovr_idx | output | ADDR_W-2 | Dword index offered to override logic |
| ovr_valid | input | 1 | Override value present |
| ovr_data | input | 32 | Override dword value |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Illegal size |
| rsp_rdata | output | 32 | Read data |
| wn_valid | output | 1 | Write notification strobe |
| wn_idx | output | ADDR_W-2 | Written dword index |
| wn_old | output | 32 | Value before the write |
| wn_new | output | 32 | Value after the write |
| wn_mask | output | 32 | Byte lane mask |

## Verification
The bound checker tests these rules on every cycle:
- a response follows each request by exactly one cycle;
- errored and out-of-range accesses stay silent and return zero;
- a notification only follows a write;
- no notified change falls outside the lane mask;
- no bit rises unless the shifted write data carried a 1 there.

The exact per-bit class tables, reset contents, sub-dword extraction and the override's effect on reads and on write merges can only be shown by the bench's sweeps. These compare every dword against a model built from the requirement masks. A second instance built without the capability shows the shorter region and the zero capability pointer.

// File: rtl/cfg_bridge_regfile.sv
module cfg_bridge_regfile #(
  parameter bit          HAS_CAP = 1'b1,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] ID_WORD = 32'h7a11_1d5e,
  parameter logic [7:0]  REV_ID  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [ADDR_W-3:0] ovr_idx,
  input  logic              ovr_valid,
  input  logic [31:0]       ovr_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              wn_valid,
  output logic [ADDR_W-3:0] wn_idx,
  output logic [31:0]       wn_old,
  output logic [31:0]       wn_new,
  output logic [31:0]       wn_mask
);
  localparam int NDW = HAS_CAP ? 31 : 16;
  localparam int IW  = $clog2(NDW);

  function automatic logic [31:0] f_rw(input int i);
    case (i)
      1:  return 32'h0000_0147;
      6:  return 32'h00FF_FFFF;
      7:  return 32'h0000_F0F0;
      8, 9: return 32'hFFF0_FFF0;
      10, 11, 12: return 32'hFFFF_FFFF;
      14: return 32'hFFFF_F801;
      15: return 32'h0B6F_00FF;
      18: return 32'h0000_FFFF;
      20: return 32'h0000_0FFB;
      22: return 32'h0000_1FFF;
      23: return 32'h0000_001F;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] f_w1c(input int i);
    case (i)
      1, 7: return 32'hF900_0000;
      15: return 32'h0400_0000;
      18: return 32'h000F_0000;
      20: return 32'hC000_0000;
      22: return 32'h011F_0000;
      24: return 32'h0001_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] f_rsvd(input int i);
    case (i)
      1:  return 32'h004F_FC00;
      7:  return 32'h005F_0000;
      13: return 32'hFFFF_FF00;
      14: return 32'h0000_07FE;
      15: return 32'hF010_0000;
      18: return 32'hFFE0_0000;
      19: return 32'h0080_0000;
      20: return 32'h0000_F004;
      22: return 32'hFE00_E000;
      23: return 32'hFFFE_FFE0;
      24: return 32'hFFFC_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] f_init(input int i);
    case (i)
      0:  return ID_WORD;
      1:  return 32'h0010_0000;
      2:  return {16'h0604, 8'h00, REV_ID};
      3:  return 32'h0001_0010;
      13: return HAS_CAP ? 32'h0000_0040 : 32'h0;
      16: return HAS_CAP ? 32'h0142_0010 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  logic [31:0] mem [NDW];
  logic [ADDR_W-3:0] idx;
  logic [4:0]  sh;
  logic        in_rng, size_ok, do_wr;
  logic [31:0] cur, bmask, wd, nxt, rdat, rw_m, w1c_m;

  assign idx     = req_addr[ADDR_W-1:2];
  assign ovr_idx = idx;
  assign sh      = {req_addr[1:0], 3'b000};
  assign in_rng  = int'(idx) < NDW;
  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign do_wr   = req_valid && req_write && in_rng && size_ok;
  assign rw_m    = f_rw(int'(idx));
  assign w1c_m   = f_w1c(int'(idx));
  assign wd      = req_wdata << sh;
  assign bmask   = (req_size == 3'd4) ? 32'hFFFF_FFFF :
                   (req_size == 3'd2) ? (32'h0000_FFFF << sh) : (32'h0000_00FF << sh);

  always_comb begin
    cur = 32'h0;
    if (in_rng)
      cur = (ovr_valid ? ovr_data : mem[idx[IW-1:0]]) & ~f_rsvd(int'(idx));
    nxt  = ((cur & ~(rw_m & bmask)) | (wd & rw_m & bmask)) & ~(wd & w1c_m & bmask);
    rdat = cur >> sh;
    if (req_size == 3'd1)      rdat = rdat & 32'h0000_00FF;
    else if (req_size == 3'd2) rdat = rdat & 32'h0000_FFFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDW; i++) mem[i] <= f_init(i);
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
      wn_valid  <= 1'b0;
      wn_idx    <= '0;
      wn_old    <= 32'h0;
      wn_new    <= 32'h0;
      wn_mask   <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && in_rng && !size_ok;
      rsp_rdata <= (req_valid && !req_write && in_rng && size_ok) ? rdat : 32'h0;
      wn_valid  <= do_wr;
      if (do_wr) begin
        mem[idx[IW-1:0]] <= nxt;
        wn_idx  <= idx;
        wn_old  <= cur;
        wn_new  <= nxt;
        wn_mask <= bmask;
      end
    end
  end
endmodule

module cfg_bridge_regfile_chk #(
  parameter bit HAS_CAP = 1'b1,
  parameter int ADDR_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              wn_valid,
  input logic [31:0]       wn_old,
  input logic [31:0]       wn_new,
  input logic [31:0]       wn_mask
);
  localparam int LIMIT = HAS_CAP ? 31 : 16;
  logic prev_v, prev_oor, prev_wr;
  logic [31:0] prev_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v <= 1'b0; prev_oor <= 1'b0; prev_wr <= 1'b0; prev_wd <= 32'h0;
    end else begin
      prev_v   <= req_valid;
      prev_oor <= req_valid && (int'(req_addr[ADDR_W-1:2]) >= LIMIT);
      prev_wr  <= req_valid && req_write;
      prev_wd  <= req_wdata << {req_addr[1:0], 3'b000};
    end
  end

  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == prev_v);
  assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!wn_valid && rsp_rdata == 32'h0));
  assert_oor_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prev_oor |-> (rsp_rdata == 32'h0 && !wn_valid && !rsp_err));
  assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wn_valid |-> (((wn_old ^ wn_new) & ~wn_mask) == 32'h0));
  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wn_valid |-> ((wn_new & ~wn_old & ~prev_wd) == 32'h0));
  assert_note_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wn_valid |-> prev_wr);
endmodule

bind cfg_bridge_regfile cfg_bridge_regfile_chk #(.HAS_CAP(HAS_CAP), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .wn_valid(wn_valid),
  .wn_old(wn_old), .wn_new(wn_new), .wn_mask(wn_mask));

// File: tb/cfg_bridge_regfile_tb.sv
module cfg_bridge_regfile_tb_top;
  localparam logic [31:0] IDW = 32'hBEEF_1234;
  localparam logic [7:0]  REV = 8'h3C;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ovr_valid = 0;
  logic [11:0] req_addr = 0;
  logic [2:0]  req_size = 4;
  logic [31:0] req_wdata = 0, ovr_data = 0;
  logic [9:0]  ovr_idx, wn_idx, n_ovr_idx, n_wn_idx;
  logic rsp_valid, rsp_err, wn_valid, n_rsp_valid, n_rsp_err, n_wn_valid;
  logic [31:0] rsp_rdata, wn_old, wn_new, wn_mask, n_rsp_rdata, n_wn_old, n_wn_new, n_wn_mask;
  int ntot = 0, nfail = 0;
  logic [31:0] model [31];

  always #10 clk = ~clk;

  cfg_bridge_regfile #(.HAS_CAP(1'b1), .ADDR_W(12), .ID_WORD(IDW), .REV_ID(REV)) dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .ovr_idx, .ovr_valid, .ovr_data, .rsp_valid, .rsp_err, .rsp_rdata,
    .wn_valid, .wn_idx, .wn_old, .wn_new, .wn_mask);

  cfg_bridge_regfile #(.HAS_CAP(1'b0), .ADDR_W(12), .ID_WORD(IDW), .REV_ID(REV)) dut_nocap_i (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_size, .req_wdata,
    .ovr_idx(n_ovr_idx), .ovr_valid, .ovr_data, .rsp_valid(n_rsp_valid),
    .rsp_err(n_rsp_err), .rsp_rdata(n_rsp_rdata), .wn_valid(n_wn_valid),
    .wn_idx(n_wn_idx), .wn_old(n_wn_old), .wn_new(n_wn_new), .wn_mask(n_wn_mask));

  function automatic logic [31:0] t_rw(int i);
    case (i)
      1: return 32'h147; 6: return 32'h00FF_FFFF; 7: return 32'hF0F0;
      8, 9: return 32'hFFF0_FFF0; 10, 11, 12: return 32'hFFFF_FFFF;
      14: return 32'hFFFF_F801; 15: return 32'h0B6F_00FF; 18: return 32'hFFFF;
      20: return 32'h0FFB; 22: return 32'h1FFF; 23: return 32'h1F;
      default: return 0;
    endcase
  endfunction
  function automatic logic [31:0] t_w1c(int i);
    case (i)
      1, 7: return 32'hF900_0000; 15: return 32'h0400_0000; 18: return 32'h000F_0000;
      20: return 32'hC000_0000; 22: return 32'h011F_0000; 24: return 32'h0001_0000;
      default: return 0;
    endcase
  endfunction
  function automatic logic [31:0] t_rsvd(int i);
    case (i)
      1: return 32'h004F_FC00; 7: return 32'h005F_0000; 13: return 32'hFFFF_FF00;
      14: return 32'h7FE; 15: return 32'hF010_0000; 18: return 32'hFFE0_0000;
      19: return 32'h0080_0000; 20: return 32'hF004; 22: return 32'hFE00_E000;
      23: return 32'hFFFE_FFE0; 24: return 32'hFFFC_0000;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic op(input string rq, input bit wr, input logic [11:0] a, input logic [2:0] sz,
                    input logic [31:0] wd, input bit ov = 0, input logic [31:0] od = 0);
    int i = int'(a[11:2]);
    bit inr = i < 31;
    bit szok = (sz == 1) || (sz == 2) || (sz == 4);
    int s = 8 * int'(a[1:0]);
    logic [31:0] cur = 0, m, d, nw, ex;
    if (inr) cur = (ov ? od : model[i]) & ~t_rsvd(i);
    m  = (sz == 4) ? 32'hFFFF_FFFF : (sz == 2) ? (32'hFFFF << s) : (32'hFF << s);
    d  = wd << s;
    nw = ((cur & ~(t_rw(i) & m)) | (d & t_rw(i) & m)) & ~(d & t_w1c(i) & m);
    ex = cur >> s;
    if (sz == 1) ex = ex & 32'hFF; else if (sz == 2) ex = ex & 32'hFFFF;
    if (!inr || !szok || wr) ex = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    ovr_valid = ov; ovr_data = od;
    #1 chk("R9", "ovr_idx", {22'h0, ovr_idx}, {22'h0, a[11:2]});
    @(negedge clk);
    req_valid = 0; req_write = 0; ovr_valid = 0;
    chk("R11", "rsp_valid", {31'h0, rsp_valid}, 1);
    chk(rq, $sformatf("rsp_err @%h", a), {31'h0, rsp_err}, {31'h0, inr && !szok});
    chk(rq, $sformatf("rdata @%h sz%0d", a, sz), rsp_rdata, ex);
    chk(rq, $sformatf("wn_valid @%h", a), {31'h0, wn_valid}, {31'h0, wr && inr && szok});
    if (wr && inr && szok) begin
      chk("R10", "wn_idx", {22'h0, wn_idx}, {22'h0, a[11:2]});
      chk("R10", "wn_old", wn_old, cur);
      chk(rq, $sformatf("wn_new @%h", a), wn_new, nw);
      chk("R10", "wn_mask", wn_mask, m);
      model[i] = nw;
    end
  endtask

  initial begin
    for (int i = 0; i < 31; i++) model[i] = 0;
    model[0] = IDW; model[1] = 32'h0010_0000; model[2] = {16'h0604, 8'h00, REV};
    model[3] = 32'h0001_0010; model[13] = 32'h40; model[16] = 32'h0142_0010;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid idle", {31'h0, rsp_valid}, 0);
    chk("R1", "wn_valid idle", {31'h0, wn_valid}, 0);
    // R1 reset contents, R4 beyond the region
    for (int i = 0; i < 34; i++) op("R1", 0, 12'(i * 4), 4, 0);
    op("R1", 0, 12'h00C, 4, 0); chk("R1", "hdr dword", rsp_rdata, 32'h0001_0010);
    op("R1", 0, 12'h008, 2, 0, 0); chk("R1", "rev field", rsp_rdata, {24'h0, REV});
    op("R1", 0, 12'h00A, 2, 0); chk("R1", "class", rsp_rdata, 32'h0604);
    op("R1", 0, 12'h034, 4, 0); chk("R1", "cap ptr", rsp_rdata, 32'h40);
    chk("R1", "nocap cap ptr", n_rsp_rdata, 0);
    op("R1", 0, 12'h040, 4, 0); chk("R1", "cap hdr", rsp_rdata, 32'h0142_0010);
    chk("R4", "nocap 0x40", n_rsp_rdata, 0);
    chk("R4", "nocap no err", {31'h0, n_rsp_err}, 0);
    // R6/R8 full sweeps of ones then zeros
    for (int i = 0; i < 31; i++) op("R6", 1, 12'(i * 4), 4, 32'hFFFF_FFFF);
    for (int i = 0; i < 31; i++) op("R8", 0, 12'(i * 4), 4, 0);
    for (int i = 0; i < 124; i++) op("R6", 1, 12'(i), 1, 32'h0);
    for (int i = 0; i < 62; i++) op("R2", 0, 12'(i * 2), 2, 0);
    // R2 sub-dword patterns
    op("R2", 1, 12'h022, 2, 32'hA5C3);
    op("R2", 1, 12'h029, 1, 32'h5A);
    op("R2", 1, 12'h02B, 2, 32'h1234);
    for (int i = 0; i < 16; i++) op("R2", 0, 12'h020 + 12'(i), 1, 0);
    op("R2", 0, 12'h02A, 2, 0);
    op("R2", 0, 12'h029, 4, 0);
    // R3 illegal sizes
    for (int s = 0; s < 8; s++)
      if (s != 1 && s != 2 && s != 4) op("R3", 1, 12'h028, 3'(s), 32'hDEAD_BEEF);
    op("R3", 0, 12'h028, 4, 0);
    // R4 region edge
    op("R4", 1, 12'h078, 4, 32'hFFFF_FFFF);
    op("R4", 1, 12'h07C, 4, 32'hFFFF_FFFF);
    op("R4", 1, 12'h3FC, 3, 32'hFFFF_FFFF);
    op("R4", 1, 12'h040, 4, 32'hFFFF_FFFF);
    chk("R4", "nocap write dropped", {31'h0, n_wn_valid}, 0);
    // R5/R9 override, R7 W1C via override
    op("R5", 0, 12'h034, 4, 0, 1, 32'hFFFF_FFFF);
    chk("R5", "rsvd masked ovr", rsp_rdata, 32'hFF);
    op("R9", 0, 12'h010, 4, 0, 1, 32'h1357_9BDF);
    op("R7", 1, 12'h004, 4, 32'h0100_0000, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h006, 2, 32'hF900, 1, 32'hFFFF_FFFF);
    op("R7", 0, 12'h004, 4, 0);
    op("R7", 1, 12'h01E, 1, 32'h80, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h03F, 1, 32'h04, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h04A, 2, 32'h0005, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h052, 2, 32'hC000, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h050, 2, 32'hC000, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h05A, 2, 32'h011F, 1, 32'hFFFF_FFFF);
    op("R7", 1, 12'h060, 4, 32'h0001_0000, 1, 32'hFFFF_FFFF);
    for (int i = 0; i < 31; i++) op("R10", 0, 12'(i * 4), 4, 0);
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    ntot++; nfail++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule